// File: doc/BRIEF.md
# Video Memory Slot Arbiter

This block lets a display refresh engine and a CPU share one single-ported video memory. A free-running slot phase splits time into display slots and CPU slots. The memory address bus carries the display address in display slots and the latched CPU address in all other slots. The display side supplies a word address. The block fetches that word and presents it on `fetch_data`, with a one-clock `fetch_load` strobe for the downstream shift register.

There are two modes. In bitmap mode (`mode_bitmap`=1), display and CPU slots alternate on every clock during active display. A CPU access is stalled with `cpu_wait` only until its slot comes round. The display base comes from a screen select: four screens in normal width, or two in double width. In character mode (`mode_bitmap`=0), every clock of active display is a display fetch from the low 4K words. Any CPU access is then held with `cpu_wait` until blanking. During blanking every slot belongs to the CPU.

A CPU write can be a plain store or a read-modify-write that merges the CPU data into the stored word. A merge costs two CPU slots, a read and then a write-back. `cpu_wait` covers both slots.

The controller has three states:
- IDLE: no access is held.
- PEND: a request is latched and waits for a CPU slot.
- WBACK: a merged word waits for its write slot.

Its transitions are:
- IDLE→PEND: a request is accepted.
- PEND→IDLE: a read or plain write completes in a CPU slot.
- PEND→WBACK: the read half of a merge completes.
- WBACK→IDLE: the write-back commits.
- PEND and WBACK hold while no CPU slot is available.

Top module: `vram_arbiter`

## Requirements
- R1: After reset `cpu_wait`, `fetch_load` and `mem_we` are all 0.
- R2: During blanking, a read or plain write (op 00) accepted on one clock edge completes on the next edge. `cpu_wait` is high for exactly one clock, and read data is valid on `cpu_rdata` when `cpu_wait` falls.
- R3: Write ops are encoded as 00 store, 01 OR, 10 XOR and 11 clear. Clear stores the memory word AND NOT the CPU data. Ops 01–11 take two CPU slots, so `cpu_wait` lasts two clocks in blanking.
- R4: In bitmap mode during active display, `fetch_load` is high on alternate clocks.
- R5: In bitmap mode during active display, `cpu_wait` lasts at most 2 clocks for a read or store, and at most 4 clocks for a merged write.
- R6: A memory write never occupies a display slot. A clock with `mem_we` high is never followed by a `fetch_load` pulse.
- R7: In character mode, a CPU access requested during active display keeps `cpu_wait` high while `active` stays high. It completes one clock after `active` falls.
- R8: In character mode the fetch address is the low 12 bits of `disp_addr`, zero-extended. For example, cell 0x3C0 is fetched for any `disp_addr` ending in 0x3C0.
- R9: In bitmap mode the fetch address is {`scr_sel`, `disp_addr`[AW-3:0]}. In double-width mode (`wide_mode`=1) it is {`scr_sel`[0], `disp_addr`[AW-2:0]}.
- R10: `fetch_load` rises one clock after a display slot, with `fetch_data` equal to the memory word at that slot's fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_bitmap | input | 1 | 1 = bitmap slot interleave, 0 = character mode |
| wide_mode | input | 1 | Double-width bitmap screen layout |
| active | input | 1 | Active display period (0 = blanking) |
| scr_sel | input | 2 | Bitmap screen select |
| disp_addr | input | AW | Display word address |
| cpu_req | input | 1 | One-clock CPU access request |
| cpu_we | input | 1 | Request is a write |
| cpu_op | input | 2 | Write operation code |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | DW | CPU write data |
| cpu_wait | output | 1 | CPU stall |
| cpu_rdata | output | DW | CPU read data |
| fetch_data | output | DW | Fetched display word |
| fetch_load | output | 1 | Display word load strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | DW | Memory read data (combinational read) |

## Verification
The assertions assume some behaviour from the block's inputs:
- `cpu_req` is raised only while `cpu_wait` is low.
- `mode_bitmap` changes only during blanking.
- The memory returns read data in the same clock as the address.

The bench keeps to these assumptions. It switches modes only with `active` low, issues each request as a single-clock pulse after the previous access has finished, and models the memory as a combinational lookup over a pattern overlaid with a write log. Requests in bitmap mode are issued on both slot phases, so that both the aligned and the misaligned stall lengths occur.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;
    typedef enum logic [1:0] {
        OP_PUT = 2'b00,
        OP_OR  = 2'b01,
        OP_XOR = 2'b10,
        OP_CLR = 2'b11
    } wr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PEND,
        ST_WBACK
    } arb_state_e;
endpackage

// File: rtl/slot_phase.sv
module slot_phase (
    input  logic clk,
    input  logic rst_n,
    output logic cpu_phase
);
    always_ff @(posedge clk) begin
        if (!rst_n) cpu_phase <= 1'b0;
        else        cpu_phase <= ~cpu_phase;
    end
endmodule

// File: rtl/merge_unit.sv
module merge_unit
    import vram_arb_pkg::*;
#(
    parameter int DW = 8
) (
    input  wr_op_e        op,
    input  logic [DW-1:0] old_word,
    input  logic [DW-1:0] cpu_word,
    output logic [DW-1:0] new_word
);
    always_comb begin
        unique case (op)
            OP_PUT: new_word = cpu_word;
            OP_OR:  new_word = old_word | cpu_word;
            OP_XOR: new_word = old_word ^ cpu_word;
            OP_CLR: new_word = old_word & ~cpu_word;
        endcase
    end
endmodule

// File: rtl/fetch_addr_map.sv
module fetch_addr_map #(
    parameter int AW     = 14,
    parameter int LEG_AW = 12
) (
    input  logic          bitmap,
    input  logic          wide,
    input  logic [1:0]    scr_sel,
    input  logic [AW-1:0] disp_addr,
    output logic [AW-1:0] fetch_addr
);
    localparam int PAD = AW - LEG_AW;

    logic [AW-1:0] leg_addr;

    generate
        if (PAD > 0) begin : g_pad
            assign leg_addr = {{PAD{1'b0}}, disp_addr[LEG_AW-1:0]};
        end else begin : g_nopad
            assign leg_addr = disp_addr;
        end
    endgenerate

    always_comb begin
        if (!bitmap)   fetch_addr = leg_addr;
        else if (wide) fetch_addr = {scr_sel[0], disp_addr[AW-2:0]};
        else           fetch_addr = {scr_sel, disp_addr[AW-3:0]};
    end
endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
    import vram_arb_pkg::*;
#(
    parameter int AW     = 14,
    parameter int DW     = 8,
    parameter int LEG_AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_bitmap,
    input  logic          wide_mode,
    input  logic          active,
    input  logic [1:0]    scr_sel,
    input  logic [AW-1:0] disp_addr,
    input  logic          cpu_req,
    input  logic          cpu_we,
    input  logic [1:0]    cpu_op,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_wait,
    output logic [DW-1:0] cpu_rdata,
    output logic [DW-1:0] fetch_data,
    output logic          fetch_load,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata
);
    arb_state_e    state, state_nx;
    logic          cpu_phase;
    logic          disp_slot;
    logic          grant;
    logic [AW-1:0] f_addr;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_wdata;
    logic          r_we;
    wr_op_e        r_op;
    logic [DW-1:0] merged;
    logic [DW-1:0] wbuf;
    logic          is_merge;

    slot_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_phase (cpu_phase)
    );

    fetch_addr_map #(.AW(AW), .LEG_AW(LEG_AW)) u_map (
        .bitmap     (mode_bitmap),
        .wide       (wide_mode),
        .scr_sel    (scr_sel),
        .disp_addr  (disp_addr),
        .fetch_addr (f_addr)
    );

    merge_unit #(.DW(DW)) u_merge (
        .op       (r_op),
        .old_word (mem_rdata),
        .cpu_word (r_wdata),
        .new_word (merged)
    );

    // Display owns every active clock in character mode and the even phase in bitmap mode.
    assign disp_slot = active && (!mode_bitmap || !cpu_phase);
    assign grant     = !disp_slot;
    assign is_merge  = r_we && (r_op != OP_PUT);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cpu_req) state_nx = ST_PEND;
            ST_PEND:  if (grant)   state_nx = is_merge ? ST_WBACK : ST_IDLE;
            ST_WBACK: if (grant)   state_nx = ST_IDLE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // Memory port outputs
    always_comb begin
        mem_addr  = disp_slot ? f_addr : r_addr;
        mem_wdata = r_wdata;
        mem_we    = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PEND:  mem_we = grant && r_we && !is_merge;
            ST_WBACK: begin
                mem_we    = grant;
                mem_wdata = wbuf;
            end
            default: ;
        endcase
    end

    assign cpu_wait = (state != ST_IDLE);

    // Request capture and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr     <= '0;
            r_wdata    <= '0;
            r_we       <= 1'b0;
            r_op       <= OP_PUT;
            wbuf       <= '0;
            cpu_rdata  <= '0;
            fetch_data <= '0;
            fetch_load <= 1'b0;
        end else begin
            if (state == ST_IDLE && cpu_req) begin
                r_addr  <= cpu_addr;
                r_wdata <= cpu_wdata;
                r_we    <= cpu_we;
                r_op    <= wr_op_e'(cpu_op);
            end
            if (state == ST_PEND && grant) begin
                if (!r_we)    cpu_rdata <= mem_rdata;
                if (is_merge) wbuf      <= merged;
            end
            fetch_load <= disp_slot;
            if (disp_slot) fetch_data <= mem_rdata;
        end
    end
endmodule

// File: rtl/vram_arbiter_chk.sv
module vram_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_bitmap,
    input logic active,
    input logic cpu_req,
    input logic cpu_wait,
    input logic fetch_load,
    input logic mem_we
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!cpu_wait && !fetch_load && !mem_we));

    // R2
    req_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_wait) |=> cpu_wait);

    // R3
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wait |-> !mem_we);

    // R4
    load_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_bitmap && fetch_load) |=> !fetch_load);

    // R6
    write_not_in_disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !fetch_load);

    // R7
    char_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_bitmap && active && cpu_wait) |=> cpu_wait);
endmodule

bind vram_arbiter vram_arbiter_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_bitmap (mode_bitmap),
    .active      (active),
    .cpu_req     (cpu_req),
    .cpu_wait    (cpu_wait),
    .fetch_load  (fetch_load),
    .mem_we      (mem_we)
);

// File: tb/sim_vram_arbiter.sv
`timescale 1ns/1ps
module sim_vram_arbiter;
    localparam int AW = 14;
    localparam int DW = 8;
    localparam int NLOG = 64;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          mode_bitmap = 0, wide_mode = 0, active = 0;
    logic [1:0]    scr_sel = 0;
    logic [AW-1:0] disp_addr = 0;
    logic          cpu_req = 0, cpu_we = 0;
    logic [1:0]    cpu_op = 0;
    logic [AW-1:0] cpu_addr = 0;
    logic [DW-1:0] cpu_wdata = 0;
    logic          cpu_wait, fetch_load, mem_we;
    logic [DW-1:0] cpu_rdata, fetch_data, mem_wdata, mem_rdata;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int errors = 0;
    int sched_viol = 0;
    logic prev_we = 0;

    logic [AW-1:0] log_a [NLOG];
    logic [DW-1:0] log_d [NLOG];
    int            log_n = 0;

    always #4 clk = ~clk;

    vram_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .mode_bitmap(mode_bitmap), .wide_mode(wide_mode),
        .active(active), .scr_sel(scr_sel), .disp_addr(disp_addr),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_op(cpu_op), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_wait(cpu_wait), .cpu_rdata(cpu_rdata),
        .fetch_data(fetch_data), .fetch_load(fetch_load), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata)
    );

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
    endfunction

    // Memory model: pattern overlaid with a log of writes
    always_comb begin
        mem_rdata = pat(mem_addr);
        for (int i = 0; i < NLOG; i++)
            if (i < log_n && log_a[i] == mem_addr) mem_rdata = log_d[i];
    end

    always @(posedge clk) begin
        if (mem_we && log_n < NLOG) begin
            log_a[log_n] <= mem_addr;
            log_d[log_n] <= mem_wdata;
            log_n <= log_n + 1;
        end
    end

    // R6 monitor: a write clock must never be followed by a load strobe
    always @(negedge clk) begin
        if (rst_n && prev_we && fetch_load) sched_viol++;
        prev_we <= mem_we;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_access(input logic we, input logic [1:0] op, input logic [AW-1:0] a,
                              input logic [DW-1:0] d, output int waits, output logic [DW-1:0] rd);
        cpu_req = 1; cpu_we = we; cpu_op = op; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 0;
        waits = 0;
        while (cpu_wait && waits < 60) begin
            waits++;
            @(negedge clk);
        end
        rd = cpu_rdata;
    endtask

    task automatic t_reset();
        // R1
        chk(!cpu_wait && !fetch_load && !mem_we, "R1",
            {cpu_wait, fetch_load, mem_we}, 0);
    endtask

    task automatic t_blank_ops();
        int w; logic [DW-1:0] rd;
        mode_bitmap = 1; active = 0;
        cpu_access(1, 2'b00, 14'h0100, 8'h3C, w, rd);
        chk(w == 1, "R2 store wait", w, 1);
        cpu_access(0, 2'b00, 14'h0100, 8'h00, w, rd);
        chk(w == 1 && rd == 8'h3C, "R2 read", rd, 8'h3C);
        cpu_access(1, 2'b01, 14'h0100, 8'h81, w, rd);
        chk(w == 2, "R3 merge wait", w, 2);
        cpu_access(0, 2'b00, 14'h0100, 8'h00, w, rd);
        chk(rd == 8'hBD, "R3 OR", rd, 8'hBD);
        cpu_access(1, 2'b10, 14'h0100, 8'hFF, w, rd);
        cpu_access(0, 2'b00, 14'h0100, 8'h00, w, rd);
        chk(rd == 8'h42, "R3 XOR", rd, 8'h42);
        cpu_access(1, 2'b11, 14'h0100, 8'h02, w, rd);
        cpu_access(0, 2'b00, 14'h0100, 8'h00, w, rd);
        chk(rd == 8'h40, "R3 CLR", rd, 8'h40);
        cpu_access(0, 2'b00, 14'h0777, 8'h00, w, rd);
        chk(rd == pat(14'h0777), "R2 pattern read", rd, pat(14'h0777));
    endtask

    task automatic t_bitmap_active();
        int w; logic [DW-1:0] rd; logic [DW-1:0] exp;
        logic last;
        mode_bitmap = 1; wide_mode = 0; scr_sel = 2'd2; disp_addr = 14'h0005;
        active = 1;
        @(negedge clk); @(negedge clk);
        last = fetch_load;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            // R4
            chk(fetch_load != last, "R4 alternate", fetch_load, !last);
            // R9, R10
            if (fetch_load)
                chk(fetch_data == pat(14'h2005), "R9 R10 screen fetch", fetch_data, pat(14'h2005));
            last = fetch_load;
        end
        exp = 8'h40;
        for (int k = 0; k < 2; k++) begin
            cpu_access(0, 2'b00, 14'h0100, 8'h00, w, rd);
            chk(w <= 2 && rd == exp, "R5 active read", {w[7:0], rd}, {8'd2, exp});
            cpu_access(1, 2'b01, 14'h0100, 8'h01 << k, w, rd);
            chk(w >= 2 && w <= 4, "R5 active merge wait", w, 4);
            exp = exp | (8'h01 << k);
            @(negedge clk);
        end
        wide_mode = 1; scr_sel = 2'd1; disp_addr = 14'h1234;
        @(negedge clk); @(negedge clk);
        if (!fetch_load) @(negedge clk);
        chk(fetch_load && fetch_data == pat(14'h3234), "R9 wide fetch", fetch_data, pat(14'h3234));
        active = 0; wide_mode = 0;
        @(negedge clk); @(negedge clk);
        cpu_access(0, 2'b00, 14'h0100, 8'h00, w, rd);
        chk(rd == exp, "R5 merge result", rd, exp);
    endtask

    task automatic t_char_mode();
        int w; logic [DW-1:0] rd; int held;
        mode_bitmap = 0; active = 0;
        @(negedge clk);
        disp_addr = 14'h13C0; active = 1;
        @(negedge clk); @(negedge clk);
        chk(fetch_load && fetch_data == pat(14'h03C0), "R8 char fetch", fetch_data, pat(14'h03C0));
        cpu_req = 1; cpu_we = 1; cpu_op = 2'b00; cpu_addr = 14'h0200; cpu_wdata = 8'hA7;
        @(negedge clk);
        cpu_req = 0;
        held = 0;
        for (int i = 0; i < 20; i++) begin
            if (cpu_wait) held++;
            // R8: every active clock is a display fetch
            if (i == 10) chk(fetch_load, "R8 load each clock", fetch_load, 1);
            @(negedge clk);
        end
        chk(held == 20, "R7 held in active", held, 20);
        active = 0;
        @(negedge clk);
        chk(!cpu_wait, "R7 release after blank", cpu_wait, 0);
        cpu_access(0, 2'b00, 14'h0200, 8'h00, w, rd);
        chk(rd == 8'hA7, "R7 write landed", rd, 8'hA7);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_blank_ops();
        t_bitmap_active();
        t_char_mode();
        // R6
        chk(sched_viol == 0, "R6 no write in display slot", sched_viol, 0);
        summary();
        $finish;
    end
endmodule